// File: doc/BRIEF.md
# Split-Permission Address Translation Cache

This block is a small direct-mapped cache of virtual-to-physical page translations for a processor's memory unit. Every slot holds one physical page base and three virtual page tags: one for loads, one for stores and one for instruction fetches. A tag is written only when that kind of access is allowed. A lookup therefore checks permission and translates with one tag compare against the tag chosen by the access type. A tag value of all ones marks it empty.

A lookup presents a virtual address and an access type. One cycle later the block reports either a hit with the physical address, or a miss. A miss is the request to the surrounding logic to fetch the leaf page table entry. That logic then hands the entry back through the refill channel, together with the virtual address, the access type and the privilege mode. The block checks the entry's permissions. It either raises a typed access fault or installs the translation, and it answers one cycle later with the translated address.

A flush empties every tag in one cycle and, one cycle later, pulses an invalidate to the instruction cache. Walking the page tables and holding cached data are done elsewhere.

Top module: `pxlat_tlb`

## Requirements
- R1: In the cycles of a synchronous active-high reset, and in the cycle after the last one, every output is low except `rf_ready`. After reset every tag is empty, so every lookup misses until a refill installs an entry.
- R2: A lookup with `lk_valid` high gives `rsp_valid` high in the next cycle. The virtual page number (VPN) is `lk_vaddr >> PG_SHIFT`. The slot index is VPN modulo `ENTRIES`. `rsp_hit` is high when the tag for the access type in that slot equals the VPN; otherwise `rsp_miss` is high. Exactly one of the two is high when `rsp_valid` is high.
- R3: Access type encoding on `lk_type` and `rf_type`: 2'b00 is a load, 2'b01 is a store, and 2'b10 or 2'b11 is a fetch. A lookup compares only the tag for its own type.
- R4: Page table entry flags: bit 0 valid, bit 1 user execute, bit 2 user write, bit 3 user read, bit 4 supervisor execute, bit 5 supervisor write, bit 6 supervisor read. When `rf_super` is high, the supervisor bits stand in for the user bits in every permission check.
- R5: A refill faults when the entry's valid bit or the permission bit for its access type is clear. The fault is reported on `fill_fault` as 1 for a load, 2 for a store and 3 for a fetch; 0 means no fault. A refill that faults changes no tag.
- R6: A refill that does not fault overwrites its slot. It sets the load, store and fetch tags to the VPN only where read, write and execute are permitted, and sets each other tag to empty.
- R7: `fill_badaddr` carries the virtual address of a load or store fault. It is zero for a fetch fault and for a refill with no fault.
- R8: A refill with no fault returns `fill_paddr` = the entry's upper bits from `PG_SHIFT` up, followed by the page offset of the virtual address. A lookup hit returns the installed page base followed by the offset. Both addresses are zero on a fault or a miss.
- R9: A flush empties every tag of every slot at the clock edge. `icache_inv` is high for exactly the cycle after each cycle in which `flush` is high.
- R10: While `flush` is high, `rf_ready` is low, the refill is not taken, and no `fill_done` follows.
- R11: A lookup sees the tags as they were before the same edge's refill or flush. Refill responses come one cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_type | input | 2 | Lookup access type |
| lk_vaddr | input | VA_W | Lookup virtual address |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | Refill needed |
| rsp_paddr | output | PA_W | Physical address on a hit |
| rf_valid | input | 1 | Refill offered |
| rf_ready | output | 1 | Refill can be taken |
| rf_type | input | 2 | Access type of the refill |
| rf_vaddr | input | VA_W | Virtual address of the refill |
| rf_pte | input | PA_W | Leaf page table entry |
| rf_super | input | 1 | Supervisor privilege for the refill |
| fill_done | output | 1 | Refill answer present |
| fill_fault | output | 2 | Fault code of the refill |
| fill_badaddr | output | VA_W | Faulting address for loads and stores |
| fill_paddr | output | PA_W | Translated address of the refill |
| flush | input | 1 | Empty all tags |
| icache_inv | output | 1 | Instruction cache invalidate pulse |

## Verification
Directed sequences install entries whose permission sets differ only in one flag. A lookup hits for the permitted types and misses for the others, which exposes a tag written for the wrong type or shared between types. Entries with supervisor-only flags are refilled in both privilege modes: the flags are accepted in supervisor mode and fault in user mode, which shows whether the bit shift is applied. Two addresses that fall on the same slot, a lookup in the same cycle as a refill, and a flush that collides with a refill separate eviction, pre-edge lookup ordering and flush priority. A long stretch of random lookups, refills and flushes over a small page set then exercises aliasing and overwriting against the bench's model.

// File: rtl/pxlat_pkg.sv
package pxlat_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LOAD  = 2'd1,
    FLT_STORE = 2'd2,
    FLT_FETCH = 2'd3
  } flt_e;

  // entry flag positions; supervisor bits sit SUP_SHIFT above user bits
  localparam int PB_V  = 0;
  localparam int PB_UX = 1;
  localparam int PB_UW = 2;
  localparam int PB_UR = 3;
  localparam int PB_SX = 4;
  localparam int PERM_LO = 1;
  localparam int PERM_HI = 6;
  localparam int SUP_SHIFT = PB_SX - PB_UX;

  function automatic acc_e decode_acc(input logic [1:0] t);
    if (t[1])      return ACC_FETCH;
    else if (t[0]) return ACC_STORE;
    else           return ACC_LOAD;
  endfunction

endpackage

// File: rtl/pxlat_perm.sv
module pxlat_perm
  import pxlat_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             sup,
  input  acc_e             acc,
  output logic [2:0]       grant,
  output logic             fault,
  output flt_e             code
);

  localparam logic [PTE_W-1:0] ONE = PTE_W'(1);
  localparam logic [PTE_W-1:0] PMASK =
    ((ONE << (PERM_HI + 1)) - ONE) ^ ((ONE << PERM_LO) - ONE);

  logic [PTE_W-1:0] eff;
  logic             need;

  always_comb begin
    if (sup) eff = ((pte & PMASK) >> SUP_SHIFT) & PMASK;
    else     eff = pte & PMASK;
    eff[PB_V] = pte[PB_V];
    // grant order: load, store, fetch
    grant = {eff[PB_UX], eff[PB_UW], eff[PB_UR]};
    case (acc)
      ACC_STORE: need = grant[1];
      ACC_FETCH: need = grant[2];
      default:   need = grant[0];
    endcase
    fault = !(need && eff[PB_V]);
    if (!fault)                code = FLT_NONE;
    else if (acc == ACC_FETCH) code = FLT_FETCH;
    else if (acc == ACC_STORE) code = FLT_STORE;
    else                       code = FLT_LOAD;
  end

endmodule

// File: rtl/pxlat_store.sv
module pxlat_store #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [VPN_W-1:0]      wr_vpn,
  input  logic [2:0]            wr_grant,
  input  logic [PPN_W-1:0]      wr_ppn,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [2:0][VPN_W-1:0] rd_tag,
  output logic [PPN_W-1:0]      rd_ppn
);

  // one tag array per access type: 0 load, 1 store, 2 fetch
  for (genvar g = 0; g < 3; g++) begin : g_tag
    logic [VPN_W-1:0] tags [ENTRIES];

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        for (int i = 0; i < ENTRIES; i++) tags[i] <= '1;
      end else if (wr_en) begin
        tags[wr_idx] <= wr_grant[g] ? wr_vpn : '1;
      end
    end

    assign rd_tag[g] = tags[rd_idx];
  end

  logic [PPN_W-1:0] base [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) base[wr_idx] <= wr_ppn;
  end

  assign rd_ppn = base[rd_idx];

endmodule

// File: rtl/pxlat_tlb.sv
module pxlat_tlb
  import pxlat_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int ENTRIES  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [1:0]      lk_type,
  input  logic [VA_W-1:0] lk_vaddr,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic [PA_W-1:0] rsp_paddr,
  input  logic            rf_valid,
  output logic            rf_ready,
  input  logic [1:0]      rf_type,
  input  logic [VA_W-1:0] rf_vaddr,
  input  logic [PA_W-1:0] rf_pte,
  input  logic            rf_super,
  output logic            fill_done,
  output logic [1:0]      fill_fault,
  output logic [VA_W-1:0] fill_badaddr,
  output logic [PA_W-1:0] fill_paddr,
  input  logic            flush,
  output logic            icache_inv
);

  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;
  localparam int IDX_W = $clog2(ENTRIES);

  acc_e lk_acc, rf_acc;
  assign lk_acc = decode_acc(lk_type);
  assign rf_acc = decode_acc(rf_type);

  logic [VPN_W-1:0] lk_vpn, rf_vpn;
  assign lk_vpn = lk_vaddr[VA_W-1:PG_SHIFT];
  assign rf_vpn = rf_vaddr[VA_W-1:PG_SHIFT];

  logic [2:0][VPN_W-1:0] rd_tag;
  logic [PPN_W-1:0]      rd_ppn;
  logic                  lk_match;

  always_comb begin
    case (lk_acc)
      ACC_STORE: lk_match = (rd_tag[1] == lk_vpn);
      ACC_FETCH: lk_match = (rd_tag[2] == lk_vpn);
      default:   lk_match = (rd_tag[0] == lk_vpn);
    endcase
  end

  // flush wins: a refill is held off while it is asserted
  logic rf_fire, install;
  assign rf_ready = !flush && !rst;
  assign rf_fire  = rf_valid && rf_ready;

  logic [2:0] grant;
  logic       pfault;
  flt_e       pcode;

  pxlat_perm #(.PTE_W(PA_W)) u_perm (
    .pte   (rf_pte),
    .sup   (rf_super),
    .acc   (rf_acc),
    .grant (grant),
    .fault (pfault),
    .code  (pcode)
  );

  assign install = rf_fire && !pfault;

  pxlat_store #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .wr_en    (install),
    .wr_idx   (rf_vpn[IDX_W-1:0]),
    .wr_vpn   (rf_vpn),
    .wr_grant (grant),
    .wr_ppn   (rf_pte[PA_W-1:PG_SHIFT]),
    .rd_idx   (lk_vpn[IDX_W-1:0]),
    .rd_tag   (rd_tag),
    .rd_ppn   (rd_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_paddr    <= '0;
      fill_done    <= 1'b0;
      fill_fault   <= FLT_NONE;
      fill_badaddr <= '0;
      fill_paddr   <= '0;
      icache_inv   <= 1'b0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && lk_match;
      rsp_miss   <= lk_valid && !lk_match;
      rsp_paddr  <= (lk_valid && lk_match) ? {rd_ppn, lk_vaddr[PG_SHIFT-1:0]} : '0;
      fill_done  <= rf_fire;
      fill_fault <= rf_fire ? pcode : FLT_NONE;
      fill_badaddr <= (rf_fire && (pcode == FLT_LOAD || pcode == FLT_STORE))
                      ? rf_vaddr : '0;
      fill_paddr <= install ? {rf_pte[PA_W-1:PG_SHIFT], rf_vaddr[PG_SHIFT-1:0]} : '0;
      icache_inv <= flush;
    end
  end

endmodule

// File: rtl/pxlat_tlb_chk.sv
module pxlat_tlb_chk #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rf_valid,
  input logic [VA_W-1:0] rf_vaddr,
  input logic            fill_done,
  input logic [1:0]      fill_fault,
  input logic [VA_W-1:0] fill_badaddr,
  input logic [PA_W-1:0] fill_paddr,
  input logic            flush,
  input logic            icache_inv
);

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit ^ rsp_miss));

  // R5
  fill_origin_chk: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> $past(rf_valid));

  // R7
  fetch_noaddr_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_fault == 2'd3) |-> (fill_badaddr == '0));

  // R7
  data_badaddr_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_fault == 2'd1 || fill_fault == 2'd2) |-> (fill_badaddr == $past(rf_vaddr)));

  // R8
  fault_nopaddr_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_fault != 2'd0) |-> (fill_paddr == '0));

  // R9
  inv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> icache_inv);

  // R9
  inv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !flush |=> !icache_inv);

  // R9
  flushed_miss_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && lk_valid && (lk_vaddr[VA_W-1:PG_SHIFT] != '1)) |=> !rsp_hit);

  // R10
  flush_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_valid && flush) |=> !fill_done);

endmodule

bind pxlat_tlb pxlat_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rf_valid     (rf_valid),
  .rf_vaddr     (rf_vaddr),
  .fill_done    (fill_done),
  .fill_fault   (fill_fault),
  .fill_badaddr (fill_badaddr),
  .fill_paddr   (fill_paddr),
  .flush        (flush),
  .icache_inv   (icache_inv)
);

// File: tb/pxlat_tlb_tb.sv
module pxlat_tlb_tb;

  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int PGS  = 12;
  localparam int NENT = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst = 1'b1;
  logic            lk_valid = 1'b0;
  logic [1:0]      lk_type = 2'd0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic            rf_valid = 1'b0;
  logic [1:0]      rf_type = 2'd0;
  logic [VA_W-1:0] rf_vaddr = '0;
  logic [PA_W-1:0] rf_pte = '0;
  logic            rf_super = 1'b0;
  logic            flush = 1'b0;

  logic            rsp_valid, rsp_hit, rsp_miss, rf_ready, fill_done, icache_inv;
  logic [PA_W-1:0] rsp_paddr, fill_paddr;
  logic [1:0]      fill_fault;
  logic [VA_W-1:0] fill_badaddr;

  pxlat_tlb #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PGS), .ENTRIES(NENT)) u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_type(lk_type), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_type(rf_type), .rf_vaddr(rf_vaddr),
    .rf_pte(rf_pte), .rf_super(rf_super),
    .fill_done(fill_done), .fill_fault(fill_fault), .fill_badaddr(fill_badaddr),
    .fill_paddr(fill_paddr), .flush(flush), .icache_inv(icache_inv)
  );

  // reference model: one vpn plus a permission set per slot
  bit          m_has [NENT];
  int unsigned m_vpn [NENT];
  bit [2:0]    m_ok  [NENT];   // 0 load, 1 store, 2 fetch
  logic [19:0] m_ppn [NENT];

  logic            e_rv, e_hit, e_miss, e_done, e_inv;
  logic [PA_W-1:0] e_pa, e_fpa;
  logic [1:0]      e_flt;
  logic [VA_W-1:0] e_bad;

  int unsigned t_vpn, t_ix, t_ty;
  bit          t_h, t_r, t_w, t_x, t_need;

  int vectors = 0;
  int fails = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) m_has[i] = 0;
      {e_rv, e_hit, e_miss, e_done, e_inv} = '0;
      e_pa = '0; e_fpa = '0; e_flt = '0; e_bad = '0;
    end else begin
      // R11: lookup observes the slots before this edge's updates
      if (lk_valid) begin
        t_vpn = lk_vaddr >> PGS;
        t_ix  = t_vpn % NENT;
        t_ty  = lk_type[1] ? 2 : (lk_type[0] ? 1 : 0);
        t_h   = m_has[t_ix] && (m_vpn[t_ix] == t_vpn) && m_ok[t_ix][t_ty];
        e_rv = 1; e_hit = t_h; e_miss = !t_h;
        e_pa = t_h ? {m_ppn[t_ix], lk_vaddr[PGS-1:0]} : '0;
      end else begin
        e_rv = 0; e_hit = 0; e_miss = 0; e_pa = '0;
      end
      if (rf_valid && !flush) begin
        if (rf_super) begin t_r = rf_pte[6]; t_w = rf_pte[5]; t_x = rf_pte[4]; end
        else          begin t_r = rf_pte[3]; t_w = rf_pte[2]; t_x = rf_pte[1]; end
        t_ty   = rf_type[1] ? 2 : (rf_type[0] ? 1 : 0);
        t_need = (t_ty == 2) ? t_x : (t_ty == 1) ? t_w : t_r;
        e_done = 1;
        if (!(t_need && rf_pte[0])) begin
          e_flt = (t_ty == 2) ? 2'd3 : (t_ty == 1) ? 2'd2 : 2'd1;
          e_bad = (t_ty == 2) ? '0 : rf_vaddr;
          e_fpa = '0;
        end else begin
          e_flt = 0; e_bad = '0;
          e_fpa = {rf_pte[PA_W-1:PGS], rf_vaddr[PGS-1:0]};
          t_vpn = rf_vaddr >> PGS;
          t_ix  = t_vpn % NENT;
          m_has[t_ix] = 1; m_vpn[t_ix] = t_vpn;
          m_ok[t_ix]  = {t_x, t_w, t_r};
          m_ppn[t_ix] = rf_pte[PA_W-1:PGS];
        end
      end else begin
        e_done = 0; e_flt = 0; e_bad = '0; e_fpa = '0;
      end
      if (flush) for (int i = 0; i < NENT; i++) m_has[i] = 0;
      e_inv = flush;
    end
  end

  task automatic compare();
    vectors++;
    if (rsp_valid !== e_rv) begin fails++;
      $display("FAIL R2 rsp_valid act=%0b exp=%0b t=%0t", rsp_valid, e_rv, $time); end
    if (rsp_hit !== e_hit || rsp_miss !== e_miss) begin fails++;
      $display("FAIL R3/R6 hit/miss act=%0b/%0b exp=%0b/%0b t=%0t",
               rsp_hit, rsp_miss, e_hit, e_miss, $time); end
    if (rsp_paddr !== e_pa) begin fails++;
      $display("FAIL R8 rsp_paddr act=%h exp=%h t=%0t", rsp_paddr, e_pa, $time); end
    if (fill_done !== e_done) begin fails++;
      $display("FAIL R11 fill_done act=%0b exp=%0b t=%0t", fill_done, e_done, $time); end
    if (fill_fault !== e_flt) begin fails++;
      $display("FAIL R4/R5 fill_fault act=%0d exp=%0d t=%0t", fill_fault, e_flt, $time); end
    if (fill_badaddr !== e_bad) begin fails++;
      $display("FAIL R7 fill_badaddr act=%h exp=%h t=%0t", fill_badaddr, e_bad, $time); end
    if (fill_paddr !== e_fpa) begin fails++;
      $display("FAIL R8 fill_paddr act=%h exp=%h t=%0t", fill_paddr, e_fpa, $time); end
    if (icache_inv !== e_inv) begin fails++;
      $display("FAIL R9 icache_inv act=%0b exp=%0b t=%0t", icache_inv, e_inv, $time); end
    if (rf_ready !== (!flush && !rst)) begin fails++;
      $display("FAIL R10 rf_ready act=%0b exp=%0b t=%0t", rf_ready, !flush && !rst, $time); end
    if (rst && (rsp_valid || fill_done || icache_inv)) begin fails++;
      $display("FAIL R1 outputs active in reset act=%0b%0b%0b exp=000",
               rsp_valid, fill_done, icache_inv); end
  endtask

  task automatic cyc(input logic lv, input logic [1:0] lt, input logic [31:0] la,
                     input logic rv, input logic [1:0] rt, input logic [31:0] ra,
                     input logic [31:0] rp, input logic rs, input logic fl);
    lk_valid = lv; lk_type = lt; lk_vaddr = la;
    rf_valid = rv; rf_type = rt; rf_vaddr = ra; rf_pte = rp; rf_super = rs;
    flush = fl;
    @(negedge clk);
    compare();
  endtask

  task automatic look(input logic [1:0] t, input logic [31:0] a);
    cyc(1, t, a, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input logic [1:0] t, input logic [31:0] a, input logic [31:0] p,
                      input logic s);
    cyc(0, 0, 0, 1, t, a, p, s, 0);
  endtask

  localparam logic [31:0] A = 32'h0000_5123;
  localparam logic [31:0] B = 32'h0001_5ABC;  // same slot as A
  localparam logic [31:0] C = 32'h0000_7044;

  initial begin
    // R1: reset state
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    look(2'b00, A);                          // R1 empty after reset
    // R6: read-only user entry
    fill(2'b00, A, 32'h00ABC009, 0);
    look(2'b00, A); look(2'b01, A); look(2'b10, A);   // R3
    // R5/R7: store refill faults, reports address
    fill(2'b01, A, 32'h00ABC009, 0);
    // execute-only entry replaces the slot, 2'b11 counts as fetch
    fill(2'b10, A, 32'h00DEF003, 0);
    look(2'b10, A); look(2'b11, A); look(2'b00, A);
    // R4: supervisor-only read/write
    fill(2'b00, A, 32'h00111061, 1);
    look(2'b00, A); look(2'b01, A); look(2'b10, A);
    fill(2'b00, A, 32'h00111061, 0);          // user mode faults
    // R5: valid bit clear faults fetch with no address (R7)
    fill(2'b10, A, 32'h0022200E, 0);
    // aliasing on one slot
    fill(2'b01, B, 32'h0033300F, 0);
    look(2'b01, B); look(2'b00, A);
    // R11: same-cycle lookup and refill
    cyc(1, 2'b00, C, 1, 2'b00, C, 32'h0044400F, 0, 0);
    look(2'b00, C);
    // R9/R10: flush collides with refill
    cyc(1, 2'b01, B, 1, 2'b00, A, 32'h0055500F, 0, 1);
    look(2'b01, B); look(2'b00, C); look(2'b00, A);
    // random traffic over a small page set
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] la, ra;
      la = {20'($urandom % 48), 12'($urandom)};
      ra = {20'($urandom % 48), 12'($urandom)};
      cyc(1'($urandom % 4 != 0), 2'($urandom), la,
          1'($urandom % 3 == 0), 2'($urandom), ra,
          {20'($urandom), 5'd0, 7'($urandom)}, 1'($urandom),
          ($urandom % 25) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule